// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block models a synchronous static memory whose data bus turns from read to write and back with no idle cycles. Every command is captured on the rising clock edge: address, three chip selects of mixed polarity, a write strobe, four per-lane write strobes, a clock enable and a load/advance control. The command then travels down a two-stage pipeline. The data phase of a read and of a write both fall in the same slot, two rising edges after the command. Because of this, a read may follow a write, and a write may follow a read, on consecutive cycles without a gap.

A data word is four lanes of nine bits each. Lane i occupies bits [9i+8:9i], which are eight data bits plus one parity bit. A short burst of up to four words can follow a load. It walks the two low address bits in either linear or interleaved order. The block also provides a stall input that freezes the whole pipeline, an asynchronous output enable, and an asynchronous sleep input that blocks new commands and keeps the stored contents.

The data bus is split into `dq_in` and `dq_out`. `dq_oe` marks the cycles in which the memory would drive the shared bus; at all other times `dq_out` is zero.

Top module: `zbt_lw_sram`

## Requirements
- R1: A load cycle (`adv`=0) is accepted only when `sel1_n`=0, `sel2`=1 and `sel3_n`=0. With any other combination the cycle is a deselect: it writes nothing and causes no read data to be driven.
- R2: For a read command sampled at rising edge E, `dq_out` carries the stored word with `dq_oe`=1 from edge E+2 until edge E+3.
- R3: For a write command sampled at edge E, the data is taken from `dq_in` at edge E+2. `dq_oe` stays 0 in that data slot.
- R4: Reads and writes can be mixed on consecutive cycles with no wait state. A read issued on the cycle right after a write to the same address returns the newly written data.
- R5: A load with `we_n`=1 is a read, whatever the value of `lane_we_n`.
- R6: Lane i (bits [9i+8:9i]) of a write is stored only if `lane_we_n[i]`=0. A write with `lane_we_n`=4'hF changes no stored bits.
- R7: During a burst, `lane_we_n` is sampled again on every advance cycle and applies to that beat only.
- R8: An advance cycle (`adv`=1) after an accepted load continues the burst with the load's read/write type. With `burst_ilv`=0, beat n uses low address bits (start+n) mod 4, and the upper address bits stay fixed.
- R9: With `burst_ilv`=1, beat n uses low address bits start XOR n.
- R10: While `clk_en_n`=1, no command is accepted, nothing is written, and `dq_out` and `dq_oe` hold their values.
- R11: `oe_n`=1 forces `dq_oe`=0 and `dq_out`=0 at once, without disturbing the pipeline.
- R12: While `sleep`=1, no command is accepted, `dq_oe` is 0, and the stored contents are kept.
- R13: After reset, no data is driven (`dq_oe`=0, `dq_out`=0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the pipeline and burst state |
| addr | input | ADDR_W | Word address of a load cycle |
| sel1_n | input | 1 | Chip select, active low |
| sel2 | input | 1 | Chip select, active high |
| sel3_n | input | 1 | Chip select, active low |
| we_n | input | 1 | 0 = write, 1 = read (load cycles) |
| lane_we_n | input | LANES | Per-lane write strobes, active low |
| clk_en_n | input | 1 | Clock enable, active low; 1 stalls everything |
| adv | input | 1 | 0 = load new address, 1 = advance burst |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous low-power request |
| dq_in | input | LANES*LANE_W | Write data for the current data slot |
| dq_out | output | LANES*LANE_W | Read data, zero when not driven |
| dq_oe | output | 1 | High while read data is driven |

## Verification
The bench interleaves writes and reads cycle by cycle on the same address. A design that needs a turnaround cycle, or that reads memory before the earlier write has landed, returns stale data in the slot right after a write. Partial-lane writes and bursts whose lane strobes change on each beat expose a design that applies the wrong lane mask or keeps the strobes from the first beat. Bursts that start at a non-zero offset in both orders catch a counter that fails to wrap or that mixes up addition and XOR. Writes issued while stalled, deselected or asleep are followed by reads: a design that lets any of them through corrupts the read-back, and one that fails to freeze the output register changes `dq_out` during a stall.

// File: rtl/zbt_lw_sram.sv
module zbt_lw_sram #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic                      sel1_n,
  input  logic                      sel2,
  input  logic                      sel3_n,
  input  logic                      we_n,
  input  logic [LANES-1:0]          lane_we_n,
  input  logic                      clk_en_n,
  input  logic                      adv,
  input  logic                      burst_ilv,
  input  logic                      oe_n,
  input  logic                      sleep,
  input  logic [LANES*LANE_W-1:0]   dq_in,
  output logic [LANES*LANE_W-1:0]   dq_out,
  output logic                      dq_oe
);
  localparam int DATA_W = LANES * LANE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  wire go      = !clk_en_n;
  wire chip_on = !sel1_n && sel2 && !sel3_n;

  logic              b_act, b_wr;
  logic [ADDR_W-1:0] b_base;
  logic [1:0]        b_cnt;

  wire [1:0] cnt_nx = b_cnt + 2'd1;
  wire [1:0] low_nx = burst_ilv ? (b_base[1:0] ^ cnt_nx) : (b_base[1:0] + cnt_nx);
  wire [ADDR_W-1:0] adv_addr = {b_base[ADDR_W-1:2], low_nx};

  wire load_ok = !adv && chip_on && !sleep;
  wire adv_ok  = adv && b_act && !sleep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_act  <= 1'b0;
      b_wr   <= 1'b0;
      b_base <= '0;
      b_cnt  <= '0;
    end else if (go) begin
      if (sleep) begin
        b_act <= 1'b0;
      end else if (!adv) begin
        b_act  <= chip_on;
        b_wr   <= !we_n;
        b_base <= addr;
        b_cnt  <= '0;
      end else if (b_act) begin
        b_cnt <= cnt_nx;
      end
    end
  end

  logic              s1_v, s1_wr, s2_v, s2_wr;
  logic [ADDR_W-1:0] s1_a, s2_a;
  logic [LANES-1:0]  s1_be, s2_be;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v  <= 1'b0;
      s1_wr <= 1'b0;
      s1_a  <= '0;
      s1_be <= '0;
      s2_v  <= 1'b0;
      s2_wr <= 1'b0;
      s2_a  <= '0;
      s2_be <= '0;
    end else if (go) begin
      s1_v  <= load_ok || adv_ok;
      s1_wr <= adv ? b_wr : !we_n;
      s1_a  <= adv ? adv_addr : addr;
      s1_be <= ~lane_we_n;
      s2_v  <= s1_v;
      s2_wr <= s1_wr;
      s2_a  <= s1_a;
      s2_be <= s1_be;
    end
  end

  wire do_wr = go && s2_v && s2_wr;
  wire do_rd = go && s2_v && !s2_wr;

  logic              rd_v;
  wire [DATA_W-1:0]  rd_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    logic [LANE_W-1:0] q;

    always_ff @(posedge clk) begin
      if (do_wr && s2_be[g])
        mem[s2_a] <= dq_in[g*LANE_W +: LANE_W];
      if (do_rd)
        q <= mem[s2_a];
    end

    assign rd_q[g*LANE_W +: LANE_W] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rd_v <= 1'b0;
    else if (go) rd_v <= do_rd;
  end

  assign dq_oe  = rd_v && !oe_n && !sleep;
  assign dq_out = dq_oe ? rd_q : '0;

  p_deselect_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !adv && !chip_on) |=> !s1_v);

  p_read_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (go && s2_v && !s2_wr) |=> rd_v);

  p_write_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (go && s2_v && s2_wr) |=> !rd_v);

  p_burst_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (go && adv && b_act && !sleep) |=> (b_cnt == $past(b_cnt) + 2'd1));

  p_stall_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en_n |=> ($stable(rd_v) && $stable(s1_v) && $stable(s2_v)));

  p_sleep_block_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (go && sleep) |=> (!s1_v && !b_act));
endmodule

// File: tb/sim_zbt_lw_sram.sv
`timescale 1ns/1ps
module sim_zbt_lw_sram;
  localparam int AW = 6;
  localparam int DW = 36;
  localparam int K_NOP = 0, K_RD = 1, K_WR = 2, K_ADV = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic sel1_n = 1'b1, sel2 = 1'b0, sel3_n = 1'b1;
  logic we_n = 1'b1, clk_en_n = 1'b0, adv = 1'b0, ilv = 1'b0, oe_n = 1'b0, sleep = 1'b0;
  logic [3:0] bwn = 4'hF;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dq_out;
  logic dq_oe;

  int checks = 0, fails = 0;
  logic [DW-1:0] ref_mem [64];
  int            op_k   [16];
  logic [AW-1:0] op_a   [16];
  logic [3:0]    op_bwn [16];
  logic [DW-1:0] op_d   [16];
  logic [2:0]    op_sel [16];

  zbt_lw_sram #(.ADDR_W(AW), .LANES(4), .LANE_W(9)) u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .sel1_n(sel1_n), .sel2(sel2), .sel3_n(sel3_n),
    .we_n(we_n), .lane_we_n(bwn), .clk_en_n(clk_en_n), .adv(adv), .burst_ilv(ilv),
    .oe_n(oe_n), .sleep(sleep), .dq_in(din), .dq_out(dq_out), .dq_oe(dq_oe));

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw, input logic [3:0] m);
    logic [DW-1:0] r = old;
    for (int l = 0; l < 4; l++)
      if (!m[l]) r[l*9 +: 9] = nw[l*9 +: 9];
    return r;
  endfunction

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    {sel1_n, sel2, sel3_n} = 3'b101;
    adv = 1'b0; we_n = 1'b1; bwn = 4'hF; addr = '0;
  endtask

  task automatic clear_ops();
    for (int i = 0; i < 16; i++) begin
      op_k[i] = K_NOP; op_a[i] = '0; op_bwn[i] = 4'h0;
      op_d[i] = '0; op_sel[i] = 3'b010;
    end
  endtask

  task automatic run_seq(input int n, input string req);
    logic [AW-1:0] ea [18];
    bit ew [18], er [18];
    logic [3:0] eb [18];
    logic [AW-1:0] base = '0;
    logic [1:0] cnt = '0, lo;
    bit bwr = 0, bact = 0;
    for (int i = 0; i < n + 2; i++) begin
      ew[i] = 0; er[i] = 0; ea[i] = '0; eb[i] = 4'hF;
      idle(); clk_en_n = 1'b0;
      if (i < n) begin
        eb[i] = op_bwn[i];
        bwn = op_bwn[i];
        if (op_k[i] == K_RD || op_k[i] == K_WR) begin
          {sel1_n, sel2, sel3_n} = op_sel[i];
          we_n = (op_k[i] == K_RD);
          addr = op_a[i];
          if (op_sel[i] == 3'b010) begin
            ea[i] = op_a[i]; ew[i] = (op_k[i] == K_WR); er[i] = (op_k[i] == K_RD);
            base = op_a[i]; cnt = 2'd0; bwr = ew[i]; bact = 1;
          end else bact = 0;
        end else if (op_k[i] == K_ADV) begin
          adv = 1'b1;
          if (bact) begin
            cnt = cnt + 2'd1;
            lo = ilv ? (base[1:0] ^ cnt) : (base[1:0] + cnt);
            ea[i] = {base[AW-1:2], lo}; ew[i] = bwr; er[i] = !bwr;
          end
        end else bact = 0;
      end
      din = (i >= 2 && ew[i-2]) ? op_d[i-2] : 36'hA5A5A5A5A;
      step();
      if (i >= 2) begin
        if (ew[i-2]) ref_mem[ea[i-2]] = merge(ref_mem[ea[i-2]], op_d[i-2], eb[i-2]);
        if (er[i-2]) check(dq_oe && dq_out == ref_mem[ea[i-2]], req, dq_out, ref_mem[ea[i-2]]);
        else         check(!dq_oe && dq_out == '0, req, {35'd0, dq_oe}, '0);
      end
    end
    idle();
  endtask

  task automatic t_reset();
    check(!dq_oe && dq_out == '0, "R13 reset idle", {35'd0, dq_oe}, '0);
  endtask

  task automatic t_fill();
    clear_ops();
    for (int i = 0; i < 16; i++) begin
      op_k[i] = K_WR; op_a[i] = AW'(i); op_d[i] = {4'h1, 32'h0 + i * 32'h01010101} ^ 36'h900000000;
    end
    run_seq(16, "R3 write slot");
  endtask

  task automatic t_reads();
    clear_ops();
    for (int i = 0; i < 8; i++) begin op_k[i] = K_RD; op_a[i] = AW'(7 - i); end
    run_seq(8, "R2 read latency");
  endtask

  task automatic t_turnaround();
    clear_ops();
    op_k[0] = K_WR; op_a[0] = 6'd3; op_d[0] = 36'h123456789;
    op_k[1] = K_RD; op_a[1] = 6'd3;
    op_k[2] = K_WR; op_a[2] = 6'd4; op_d[2] = 36'hFEDCBA987;
    op_k[3] = K_RD; op_a[3] = 6'd4;
    op_k[4] = K_RD; op_a[4] = 6'd5; op_bwn[4] = 4'h0;
    op_k[5] = K_WR; op_a[5] = 6'd5; op_d[5] = 36'h0F0F0F0F0;
    op_k[6] = K_RD; op_a[6] = 6'd5; op_bwn[6] = 4'h5;
    op_k[7] = K_RD; op_a[7] = 6'd3;
    run_seq(8, "R4 R5 turnaround");
  endtask

  task automatic t_lanes();
    clear_ops();
    op_k[0] = K_WR; op_a[0] = 6'd6; op_bwn[0] = 4'b1010; op_d[0] = 36'hBBBBBBBBB;
    op_k[1] = K_WR; op_a[1] = 6'd7; op_bwn[1] = 4'hF;    op_d[1] = 36'hCCCCCCCCC;
    op_k[2] = K_WR; op_a[2] = 6'd8; op_bwn[2] = 4'b0111; op_d[2] = 36'h1FF000000;
    op_k[3] = K_RD; op_a[3] = 6'd6;
    op_k[4] = K_RD; op_a[4] = 6'd7;
    op_k[5] = K_RD; op_a[5] = 6'd8;
    run_seq(6, "R6 lane mask");
  endtask

  task automatic t_burst(input bit mode, input logic [AW-1:0] start, input string req);
    ilv = mode;
    clear_ops();
    op_k[0] = K_WR; op_a[0] = start; op_bwn[0] = 4'h0; op_d[0] = 36'h111111111;
    op_k[1] = K_ADV; op_bwn[1] = 4'b1110; op_d[1] = 36'h222222222;
    op_k[2] = K_ADV; op_bwn[2] = 4'b0000; op_d[2] = 36'h333333333;
    op_k[3] = K_ADV; op_bwn[3] = 4'b0101; op_d[3] = 36'h444444444;
    op_k[4] = K_ADV; op_bwn[4] = 4'b0000; op_d[4] = 36'h555555555;
    op_k[5] = K_RD;  op_a[5] = start;
    op_k[6] = K_ADV; op_k[7] = K_ADV; op_k[8] = K_ADV; op_k[9] = K_ADV;
    run_seq(10, req);
    ilv = 1'b0;
  endtask

  task automatic t_deselect();
    clear_ops();
    op_k[0] = K_RD; op_a[0] = 6'd2; op_sel[0] = 3'b110;
    op_k[1] = K_RD; op_a[1] = 6'd2; op_sel[1] = 3'b000;
    op_k[2] = K_RD; op_a[2] = 6'd2; op_sel[2] = 3'b011;
    op_k[3] = K_WR; op_a[3] = 6'd2; op_sel[3] = 3'b111; op_d[3] = 36'hDEADBEEF0;
    op_k[4] = K_RD; op_a[4] = 6'd2;
    run_seq(5, "R1 deselect");
  endtask

  task automatic t_stall_oe();
    logic [DW-1:0] keep = ref_mem[9];
    idle(); {sel1_n, sel2, sel3_n} = 3'b010; addr = 6'd9; step();
    idle(); step(); step();
    check(dq_oe && dq_out == keep, "R2 before stall", dq_out, keep);
    clk_en_n = 1'b1; {sel1_n, sel2, sel3_n} = 3'b010; we_n = 1'b0; bwn = 4'h0; addr = 6'd9; din = 36'h0BAD0BAD0;
    for (int k = 0; k < 3; k++) begin
      step();
      check(dq_oe && dq_out == keep, "R10 stall hold", dq_out, keep);
    end
    oe_n = 1'b1; #1;
    check(!dq_oe && dq_out == '0, "R11 oe off", dq_out, '0);
    oe_n = 1'b0; #1;
    check(dq_oe && dq_out == keep, "R11 oe back", dq_out, keep);
    clk_en_n = 1'b0; idle();
    {sel1_n, sel2, sel3_n} = 3'b010; we_n = 1'b0; bwn = 4'h0; addr = 6'd10; step();
    idle(); clk_en_n = 1'b1; din = 36'h0BAD0BAD0; step(); step();
    clk_en_n = 1'b0; step();
    din = 36'h777777777; step();
    ref_mem[10] = 36'h777777777;
    clear_ops();
    op_k[0] = K_RD; op_a[0] = 6'd9; op_k[1] = K_RD; op_a[1] = 6'd10;
    run_seq(2, "R10 stall write");
  endtask

  task automatic t_sleep();
    idle(); {sel1_n, sel2, sel3_n} = 3'b010; addr = 6'd4; step();
    idle(); step(); step();
    check(dq_oe, "R2 before sleep", {35'd0, dq_oe}, 1);
    sleep = 1'b1; #1;
    check(!dq_oe && dq_out == '0, "R12 sleep quiet", dq_out, '0);
    {sel1_n, sel2, sel3_n} = 3'b010; we_n = 1'b0; bwn = 4'h0; addr = 6'd4; din = 36'h0BAD0BAD0;
    for (int k = 0; k < 4; k++) step();
    sleep = 1'b0; idle(); step(); step(); step();
    clear_ops();
    op_k[0] = K_RD; op_a[0] = 6'd4;
    run_seq(1, "R12 sleep keeps data");
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    t_reset();
    t_fill();
    t_reads();
    t_turnaround();
    t_lanes();
    t_burst(1'b0, 6'd9, "R7 R8 linear burst");
    t_burst(1'b1, 6'd14, "R7 R9 interleaved burst");
    t_deselect();
    t_stall_oe();
    t_sleep();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule